// File: doc/BRIEF.md
# Variable-Distribution Product Term Array

This block is the programmable AND-OR plane of a small registered logic device. Twenty-two logic signals enter it, and each one is offered to every product-term row in both true and complement form. Each product-term row is the AND of the literals whose fuses are intact. The rows are then grouped. One row is a shared clear term and one is a shared preset term, both meant for the output registers. Each of the ten outputs owns one row as its drive-enable term, and it owns a run of rows that are ORed into its sum term. The runs are deliberately unequal: they are short at the two ends of the output list and long in the middle.

The configuration arrives as one flat fuse vector. Bit `row*COLS + col` is the fuse between column `col` and product row `row`. The block is purely combinational. The register macrocells sit downstream and consume `sum_o`, `oe_o`, `preset_o` and `clear_o`. The feedback signals from those macrocells come back in on `lit_in_i` together with the dedicated inputs. The geometry is parameterized: input count, output count, the shortest run and the run increment. Every row address is computed from these parameters.

Top module: `vpt_and_or_plane`

## Requirements
- R1: Input `lit_in_i[i]` drives column `2*i` in true form and column `2*i+1` in complement form (44 columns). Fuse bit `row*44+col` of `fuse_i` set to 1 means the fuse is intact and the column takes part in that row; 0 means blown.
- R2: A product row is the AND of all its connected literals. A row whose 44 fuse bits are all 0 evaluates to 1.
- R3: A row that connects both the true and the complement column of any one input evaluates to 0 for every input value.
- R4: Row 0 (fuse bits 0 to 43) drives `clear_o`.
- R5: Row 131 (fuse bits 5764 to 5807) drives `preset_o`.
- R6: Between those two rows, outputs 0 to 9 each own one enable row followed by their OR rows, in ascending row order. The run lengths for outputs 0 to 9 are 8, 10, 12, 14, 16, 16, 14, 12, 10, 8, so output 0 uses row 1 as its enable and rows 2 to 9 as its OR rows. `oe_o[k]` equals output k's enable row.
- R7: `sum_o[k]` is the OR of output k's OR rows only. Its enable row and the rows of other outputs do not contribute.
- R8: The fuse vector is 5808 bits wide (132 rows of 44), and every output follows its inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lit_in_i | input | 22 | Dedicated inputs and macrocell feedbacks |
| fuse_i | input | 5808 | Array fuse vector, 1 = intact |
| sum_o | output | 10 | Per-output OR of its product rows |
| oe_o | output | 10 | Per-output enable product term |
| preset_o | output | 1 | Shared synchronous preset term |
| clear_o | output | 1 | Shared asynchronous clear term |

## Verification
Random fuse vectors almost never produce a true sum term. With about twenty intact fuses per row, nearly every row contradicts itself or misses the input pattern, so a wrong row boundary could go unseen. The stimulus therefore blows most fuses: a quarter of the rows are left fully blank, and the rest keep only about one fuse in twenty. A directed sweep then leaves every row but one hard-wired to 0 and lets that single row follow one input. This exposes any off-by-one in the row-to-output assignment.

// File: rtl/vpt_pkg.sv
package vpt_pkg;

    typedef struct packed {
        logic [15:0] enable_row;
        logic [15:0] first_or_row;
        logic [15:0] n_terms;
    } group_loc_t;

    // OR-term count for output k: grows from the ends toward the middle
    function automatic int unsigned terms_of(int unsigned k, int unsigned nout,
                                             int unsigned tmin, int unsigned tstep);
        int unsigned mirror;
        mirror = (k < nout / 2) ? k : (nout - 1 - k);
        return tmin + tstep * mirror;
    endfunction

    function automatic int unsigned total_rows(int unsigned nout, int unsigned tmin,
                                               int unsigned tstep);
        int unsigned acc;
        acc = 2;
        for (int unsigned j = 0; j < nout; j++)
            acc = acc + 1 + terms_of(j, nout, tmin, tstep);
        return acc;
    endfunction

    function automatic group_loc_t group_loc(int unsigned k, int unsigned nout,
                                             int unsigned tmin, int unsigned tstep);
        group_loc_t loc;
        int unsigned base;
        base = 1;
        for (int unsigned j = 0; j < k; j++)
            base = base + 1 + terms_of(j, nout, tmin, tstep);
        loc.enable_row   = 16'(base);
        loc.first_or_row = 16'(base + 1);
        loc.n_terms      = 16'(terms_of(k, nout, tmin, tstep));
        return loc;
    endfunction

endpackage

// File: rtl/vpt_literal_gen.sv
module vpt_literal_gen #(
    parameter int unsigned NUM_IN = 22,
    localparam int unsigned COLS  = 2 * NUM_IN
) (
    input  logic [NUM_IN-1:0] in_i,
    output logic [COLS-1:0]   lit_o
);
    for (genvar i = 0; i < NUM_IN; i++) begin : g_col
        assign lit_o[2*i]   = in_i[i];
        assign lit_o[2*i+1] = ~in_i[i];
    end
endmodule

// File: rtl/vpt_pterm.sv
module vpt_pterm #(
    parameter int unsigned COLS = 44
) (
    input  logic [COLS-1:0] lit_i,
    input  logic [COLS-1:0] fuse_i,
    output logic            term_o
);
    // a blown fuse forces its column to a neutral 1 for the AND
    assign term_o = &(lit_i | ~fuse_i);
endmodule

// File: rtl/vpt_sum_group.sv
module vpt_sum_group #(
    parameter int unsigned N_TERMS = 8
) (
    input  logic [N_TERMS-1:0] rows_i,
    output logic               sum_o
);
    assign sum_o = |rows_i;
endmodule

// File: rtl/vpt_and_or_plane.sv
module vpt_and_or_plane #(
    parameter int unsigned NUM_IN    = 22,
    parameter int unsigned NUM_OUT   = 10,
    parameter int unsigned MIN_TERMS = 8,
    parameter int unsigned TERM_STEP = 2,
    localparam int unsigned COLS   = 2 * NUM_IN,
    localparam int unsigned ROWS   = vpt_pkg::total_rows(NUM_OUT, MIN_TERMS, TERM_STEP),
    localparam int unsigned FUSE_W = ROWS * COLS
) (
    input  logic [NUM_IN-1:0]  lit_in_i,
    input  logic [FUSE_W-1:0]  fuse_i,
    output logic [NUM_OUT-1:0] sum_o,
    output logic [NUM_OUT-1:0] oe_o,
    output logic               preset_o,
    output logic               clear_o
);
    import vpt_pkg::*;

    localparam int unsigned CLEAR_ROW  = 0;
    localparam int unsigned PRESET_ROW = ROWS - 1;

    logic [COLS-1:0] lits;
    logic [ROWS-1:0] row_terms;

    vpt_literal_gen #(.NUM_IN(NUM_IN)) lit_i (
        .in_i  (lit_in_i),
        .lit_o (lits)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        vpt_pterm #(.COLS(COLS)) pt_i (
            .lit_i  (lits),
            .fuse_i (fuse_i[r*COLS +: COLS]),
            .term_o (row_terms[r])
        );
    end

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        localparam group_loc_t LOC = group_loc(k, NUM_OUT, MIN_TERMS, TERM_STEP);
        localparam int unsigned EN_ROW = int'(LOC.enable_row);
        localparam int unsigned OR_LO  = int'(LOC.first_or_row);
        localparam int unsigned N_OR   = int'(LOC.n_terms);

        assign oe_o[k] = row_terms[EN_ROW];

        vpt_sum_group #(.N_TERMS(N_OR)) grp_i (
            .rows_i (row_terms[OR_LO +: N_OR]),
            .sum_o  (sum_o[k])
        );
    end

    assign clear_o  = row_terms[CLEAR_ROW];
    assign preset_o = row_terms[PRESET_ROW];

endmodule

// File: rtl/vpt_and_or_plane_chk.sv
module vpt_and_or_plane_chk #(
    parameter int unsigned NUM_IN    = 22,
    parameter int unsigned NUM_OUT   = 10,
    parameter int unsigned MIN_TERMS = 8,
    parameter int unsigned TERM_STEP = 2,
    localparam int unsigned COLS   = 2 * NUM_IN,
    localparam int unsigned ROWS   = vpt_pkg::total_rows(NUM_OUT, MIN_TERMS, TERM_STEP),
    localparam int unsigned FUSE_W = ROWS * COLS
) (
    input logic [NUM_IN-1:0]  lit_in_i,
    input logic [FUSE_W-1:0]  fuse_i,
    input logic [NUM_OUT-1:0] sum_o,
    input logic [NUM_OUT-1:0] oe_o,
    input logic               preset_o,
    input logic               clear_o
);
    import vpt_pkg::*;

    always_comb begin
        // R2: blank clear row is a constant 1
        if (fuse_i[0 +: COLS] == '0)
            a_r2_blank_clear: assert (clear_o);
        // R3/R5: a fully intact preset row holds contradictions
        if (&fuse_i[(ROWS-1)*COLS +: COLS])
            a_r3_full_preset: assert (!preset_o);
        // R4: a fully intact clear row is 0
        if (&fuse_i[0 +: COLS])
            a_r4_full_clear: assert (!clear_o);
    end

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_chk
        localparam group_loc_t LOC = group_loc(k, NUM_OUT, MIN_TERMS, TERM_STEP);
        localparam int unsigned EN_ROW = int'(LOC.enable_row);
        localparam int unsigned OR_LO  = int'(LOC.first_or_row);
        localparam int unsigned N_OR   = int'(LOC.n_terms);

        logic any_blank;
        logic all_full;
        always_comb begin
            any_blank = 1'b0;
            all_full  = 1'b1;
            for (int unsigned j = 0; j < N_OR; j++) begin
                if (fuse_i[(OR_LO+j)*COLS +: COLS] == '0) any_blank = 1'b1;
                if (!(&fuse_i[(OR_LO+j)*COLS +: COLS])) all_full = 1'b0;
            end
            // R7: one blank OR row forces the sum high
            if (any_blank)
                a_r7_blank_or_row: assert (sum_o[k]);
            // R7: all OR rows self-contradicting forces the sum low
            if (all_full)
                a_r7_full_or_rows: assert (!sum_o[k]);
            // R6: enable row blank gives enable high
            if (fuse_i[EN_ROW*COLS +: COLS] == '0)
                a_r6_blank_enable: assert (oe_o[k]);
        end
    end
endmodule

bind vpt_and_or_plane vpt_and_or_plane_chk #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .MIN_TERMS(MIN_TERMS), .TERM_STEP(TERM_STEP)
) chk_i (
    .lit_in_i (lit_in_i),
    .fuse_i   (fuse_i),
    .sum_o    (sum_o),
    .oe_o     (oe_o),
    .preset_o (preset_o),
    .clear_o  (clear_o)
);

// File: tb/vpt_and_or_plane_tb_top.sv
module vpt_and_or_plane_tb_top;
    localparam int NI = 22;
    localparam int NO = 10;
    localparam int NC = 44;
    localparam int NR = 132;
    localparam int FW = NR * NC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    logic [NI-1:0] lit_in;
    logic [FW-1:0] fuse;
    logic [NO-1:0] sum_w, oe_w;
    logic          preset_w, clear_w;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    vpt_and_or_plane dut_i (
        .lit_in_i (lit_in),
        .fuse_i   (fuse),
        .sum_o    (sum_w),
        .oe_o     (oe_w),
        .preset_o (preset_w),
        .clear_o  (clear_w)
    );

    // requirement-level geometry (R6)
    function automatic int run_len(int k);
        int t[10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};
        return t[k];
    endfunction

    function automatic int en_row(int k);
        int r = 1;
        for (int j = 0; j < k; j++) r += 1 + run_len(j);
        return r;
    endfunction

    // R1/R2/R3 reference product row
    function automatic logic row_val(int r);
        logic v = 1'b1;
        for (int i = 0; i < NI; i++) begin
            if (fuse[r*NC + 2*i]     && !lit_in[i]) v = 1'b0;
            if (fuse[r*NC + 2*i + 1] &&  lit_in[i]) v = 1'b0;
        end
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        logic [NO-1:0] es, eo;
        for (int k = 0; k < NO; k++) begin
            logic s = 1'b0;
            eo[k] = row_val(en_row(k));
            for (int j = 0; j < run_len(k); j++) s |= row_val(en_row(k) + 1 + j);
            es[k] = s;
        end
        check({"R7 sum ", tag}, 32'(sum_w), 32'(es));
        check({"R6 enable ", tag}, 32'(oe_w), 32'(eo));
        check({"R5 preset ", tag}, 32'(preset_w), 32'(row_val(NR-1)));
        check({"R4 clear ", tag}, 32'(clear_w), 32'(row_val(0)));
    endtask

    initial begin
        void'($urandom(32'd2024));
        lit_in = '0;
        fuse   = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2: all fuses blown -> every term is 1
        check("R2 blank sum", 32'(sum_w), 32'h3FF);
        check("R2 blank enable", 32'(oe_w), 32'h3FF);
        check("R2 blank preset/clear", 32'({preset_w, clear_w}), 32'h3);

        // R3: all intact -> every term 0, for two input patterns
        fuse = '1;
        lit_in = '0;
        #5;
        check("R3 full sum", 32'(sum_w), 32'h0);
        check("R3 full enable", 32'(oe_w), 32'h0);
        lit_in = '1;
        #5;
        check("R3 full preset/clear", 32'({preset_w, clear_w}), 32'h0);

        // R1: complement column on the preset row (R5), true column on clear row (R4)
        fuse = '1;
        fuse[(NR-1)*NC +: NC] = 44'h0;
        fuse[(NR-1)*NC + 43] = 1'b1;        // complement of input 21
        fuse[0 +: NC] = 44'h0;
        fuse[2*21] = 1'b1;                   // true of input 21
        lit_in = '0;
        #5;
        check("R1 complement col R5", 32'(preset_w), 32'h1);
        check("R1 true col R4", 32'(clear_w), 32'h0);
        lit_in[21] = 1'b1;
        #5;
        check("R1 complement col R5", 32'(preset_w), 32'h0);
        check("R1 true col R4", 32'(clear_w), 32'h1);

        // R6/R7/R8: sweep one live row across the whole plane
        for (int r = 0; r < NR; r++) begin
            fuse = '1;
            fuse[r*NC +: NC] = 44'h1;        // row r follows input 0
            for (int v = 0; v < 2; v++) begin
                lit_in = '0;
                lit_in[0] = v[0];
                #5;
                check_all($sformatf("sweep row %0d R8", r));
            end
        end
        // explicit boundary: row 9 is last OR row of output 0, row 10 is output 1 enable
        fuse = '1; fuse[9*NC +: NC] = 44'h1; lit_in = 22'h1; #5;
        check("R6 row9 -> sum0", 32'({oe_w, sum_w}), 32'h1);
        fuse = '1; fuse[10*NC +: NC] = 44'h1; #5;
        check("R6 row10 -> oe1", 32'({oe_w, sum_w}), 32'h800);

        // constrained random
        for (int n = 0; n < 400; n++) begin
            for (int r = 0; r < NR; r++) begin
                if ($urandom % 4 == 0) fuse[r*NC +: NC] = '0;
                else
                    for (int c = 0; c < NC; c++) fuse[r*NC + c] = ($urandom % 20 == 0);
            end
            lit_in = NI'($urandom);
            #5;
            check_all($sformatf("random %0d", n));
        end
        done = 1;
    end

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    errors++; checks++;
                    $display("FAIL watchdog: actual=timeout expected=done");
                end
            end
            wait (done);
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule